// File: doc/BRIEF.md
# Multichannel Output Drive Selection Logic

This block produces the registered on/off request for each of a set of low-side output channels (ten by default). Each channel has a 2-bit selection code. The code decides whether the channel follows its own input pin, its own serial control bit, or the logical AND of the two. Register contents arrive through a small write port that carries a select code and a data word.

Pairing bits tell the block that two neighbouring outputs are wired in parallel. When a pairing bit is set, the higher-numbered channel of the pair copies the command of the lower one. When several neighbouring pairing bits are set, the lowest channel of the chain commands every channel in it. A global enable forces all requests off and leaves the registers untouched. The asynchronous active-low reset returns every register to its default and turns every request off.

Top module: `drive_select`

## Requirements
- R1: While `rst_n` is low, `drive_req` is all zero. Reset sets every serial bit to 0, every selection code to 2'b10 (input pin only) and every pairing bit to 0. After reset, with `en` high, each request therefore follows its own pin.
- R2: Selection code 2'b10 makes a channel's request equal to its pin. A pin value present before a rising clock edge appears on `drive_req` after that edge.
- R3: Selection codes 2'b00 and 2'b01 make a channel's request equal to its serial bit. The pin has no effect in these codes.
- R4: Selection code 2'b11 makes a channel's request the AND of its pin and its serial bit.
- R5: A low pin forces its channel off in codes 2'b10 and 2'b11, whatever the serial bit holds.
- R6: Pairing bit k (bit 0 couples channels 0 and 1, bit k couples channel k and channel k+1) makes channel k+1 carry the command of channel k. Along a run of set pairing bits, the lowest channel of the run drives all the channels in it.
- R7: `en` low makes `drive_req` all zero after the next rising edge and leaves all registers unchanged. When `en` returns high, the requests again reflect the stored settings.
- R8: A write sampled at a rising edge updates a register at that edge, and the request reflects it after the following edge. The write select codes are:
  - 0 writes the serial bits, with data bit i going to channel i.
  - 1 writes the selection codes, with data bits [2i+1:2i] going to channel i.
  - 2 writes the pairing bits from data bits [N_CH-2:0].
  - 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low forces all requests off |
| pin_in | input | N_CH | Parallel input pins, bit i for channel i |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select code for the write |
| wr_data | input | 2*N_CH | Write data |
| drive_req | output | N_CH | Registered gate-drive request per channel |

## Verification
The bench builds the block with its defaults, N_CH = 10 and pairing enabled. With these values, a pairing chain can be as long as nine bits, covering all ten channels. The 20-bit write word can place every one of the four selection codes on every channel, including the second serial-only code 2'b01. Random writes, pin patterns and enable drops make mixed-mode channels appear together with partial and full pairing chains. Directed steps cover reset defaults, the ignored select code and the one-edge write latency.

// File: rtl/drv_sel_pkg.sv
package drv_sel_pkg;
   typedef enum logic [1:0] {
      MODE_SER_A = 2'b00,
      MODE_SER_B = 2'b01,
      MODE_PIN   = 2'b10,
      MODE_AND   = 2'b11
   } chan_mode_e;

   typedef enum logic [1:0] {
      WSEL_SER  = 2'd0,
      WSEL_MODE = 2'd1,
      WSEL_PAIR = 2'd2,
      WSEL_RSVD = 2'd3
   } wsel_e;

   localparam logic [1:0] MODE_RESET = MODE_PIN;
endpackage

// File: rtl/drv_sel_regs.sv
module drv_sel_regs
   import drv_sel_pkg::*;
#(
   parameter int N_CH = 10,
   localparam int DW  = 2 * N_CH,
   localparam int PW  = N_CH - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   output logic [N_CH-1:0] ser_q,
   output logic [DW-1:0] mode_q,
   output logic [PW-1:0] pair_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_q  <= '0;
         mode_q <= {N_CH{MODE_RESET}};
         pair_q <= '0;
      end else if (wr_en) begin
         case (wsel_e'(wr_sel))
            WSEL_SER:  ser_q  <= wr_data[N_CH-1:0];
            WSEL_MODE: mode_q <= wr_data;
            WSEL_PAIR: pair_q <= wr_data[PW-1:0];
            default:   ;
         endcase
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ser_q) && $stable(mode_q) && $stable(pair_q)); // R7

   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> $stable(ser_q) && $stable(mode_q) && $stable(pair_q)); // R8
endmodule

// File: rtl/drv_sel_mix.sv
module drv_sel_mix
   import drv_sel_pkg::*;
#(
   parameter int N_CH = 10,
   localparam int DW  = 2 * N_CH
) (
   input  logic [N_CH-1:0] pin,
   input  logic [N_CH-1:0] ser,
   input  logic [DW-1:0]   mode,
   output logic [N_CH-1:0] cmd
);
   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      always_comb begin
         case (chan_mode_e'(mode[2*i +: 2]))
            MODE_AND:   cmd[i] = pin[i] & ser[i];
            MODE_PIN:   cmd[i] = pin[i];
            MODE_SER_A,
            MODE_SER_B: cmd[i] = ser[i];
            default:    cmd[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/drv_sel_pair.sv
module drv_sel_pair #(
   parameter int N_CH    = 10,
   parameter bit PAIR_EN = 1'b1,
   localparam int PW     = N_CH - 1
) (
   input  logic [N_CH-1:0] cmd,
   input  logic [PW-1:0]   pair,
   output logic [N_CH-1:0] eff
);
   if (PAIR_EN) begin : g_chain
      always_comb begin
         eff[0] = cmd[0];
         for (int i = 1; i < N_CH; i++)
            eff[i] = pair[i-1] ? eff[i-1] : cmd[i];
      end
   end else begin : g_flat
      assign eff = cmd;
   end
endmodule

// File: rtl/drive_select.sv
module drive_select #(
   parameter int N_CH    = 10,
   parameter bit PAIR_EN = 1'b1,
   localparam int DW     = 2 * N_CH,
   localparam int PW     = N_CH - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [N_CH-1:0] pin_in,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [DW-1:0]   wr_data,
   output logic [N_CH-1:0] drive_req
);
   if (N_CH < 2 || N_CH > 16) begin : g_bad_nch
      $error("drive_select: N_CH must lie in 2..16");
   end

   logic [N_CH-1:0] ser_q;
   logic [DW-1:0]   mode_q;
   logic [PW-1:0]   pair_q;
   logic [N_CH-1:0] cmd;
   logic [N_CH-1:0] eff;

   drv_sel_regs #(.N_CH(N_CH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ser_q(ser_q), .mode_q(mode_q), .pair_q(pair_q)
   );

   drv_sel_mix #(.N_CH(N_CH)) u_mix (
      .pin(pin_in), .ser(ser_q), .mode(mode_q), .cmd(cmd)
   );

   drv_sel_pair #(.N_CH(N_CH), .PAIR_EN(PAIR_EN)) u_pair (
      .cmd(cmd), .pair(pair_q), .eff(eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_req <= '0;
      else        drive_req <= en ? eff : '0;
   end

   AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> drive_req == '0); // R7

   for (genvar i = 0; i < N_CH; i++) begin : g_chk
      logic self_src;
      if (i == 0) begin : g_first
         assign self_src = 1'b1;
      end else begin : g_rest
         assign self_src = !(PAIR_EN && pair_q[i-1]);
         if (PAIR_EN) begin : g_pc
            AST_PAIR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
               (en && pair_q[i-1]) |=> drive_req[i] == drive_req[i-1]); // R6
         end
      end

      AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (en && self_src && mode_q[2*i+1] && !pin_in[i]) |=> !drive_req[i]); // R5

      AST_SER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         (en && self_src && !mode_q[2*i+1]) |=> drive_req[i] == $past(ser_q[i])); // R3
   end
endmodule

// File: tb/drive_select_test.sv
module drive_select_test;
   localparam int CLK_NS = 10;
   localparam int N  = 10;
   localparam int DW = 2 * N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic [N-1:0] drive_req;

   int checks = 0;
   int fails  = 0;

   logic [N-1:0]  m_ser;
   logic [DW-1:0] m_mode;
   logic [N-2:0]  m_pair;

   drive_select #(.N_CH(N)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .pin_in(pin_in), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .drive_req(drive_req)
   );

   always #(CLK_NS/2) clk = ~clk;

   function automatic logic [N-1:0] expect_out(input logic [N-1:0] s, input logic [DW-1:0] md,
                                               input logic [N-2:0] pr, input logic [N-1:0] p,
                                               input logic e);
      logic [N-1:0] own;
      logic [N-1:0] res;
      for (int i = 0; i < N; i++) begin
         logic [1:0] c;
         c = md[2*i +: 2];
         if (c == 2'b11)      own[i] = p[i] && s[i];
         else if (c == 2'b10) own[i] = p[i];
         else                 own[i] = s[i];
      end
      for (int i = 0; i < N; i++) begin
         int r;
         r = i;
         while (r > 0 && pr[r-1]) r--;
         res[i] = own[r];
      end
      return e ? res : '0;
   endfunction

   task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: drive_req=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ser  = '0;
      m_mode = {N{2'b10}};
      m_pair = '0;
   endtask

   task automatic step(input logic [N-1:0] p, input logic e, input logic we,
                       input logic [1:0] s, input logic [DW-1:0] d, input string tag);
      logic [N-1:0] exp;
      pin_in = p; en = e; wr_en = we; wr_sel = s; wr_data = d;
      exp = expect_out(m_ser, m_mode, m_pair, p, e);
      if (we) begin
         case (s)
            2'd0: m_ser  = d[N-1:0];
            2'd1: m_mode = d;
            2'd2: m_pair = d[N-2:0];
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      check(drive_req, exp, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      en = 1'b1;
      pin_in = '1;
      model_reset();
      @(negedge clk);
      check(drive_req, '0, "R1 in reset");
      @(negedge clk);
      check(drive_req, '0, "R1 held in reset");
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_NS * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e_0a17));
      model_reset();
      @(negedge clk);
      do_reset();

      step(10'h3A5, 1'b1, 1'b0, 2'd0, '0, "R1 default pin mode");
      step(10'h15A, 1'b1, 1'b0, 2'd0, '0, "R2 pin follow");
      step(10'h000, 1'b1, 1'b0, 2'd0, '0, "R2 pins low");
      step(10'h3FF, 1'b1, 1'b1, 2'd1, '0, "R8 mode write not yet visible");
      step(10'h3FF, 1'b1, 1'b1, 2'd0, 20'h002C3, "R3 serial mode, old ser");
      step(10'h3FF, 1'b1, 1'b0, 2'd0, '0, "R3 serial bits, pins high");
      step(10'h000, 1'b1, 1'b0, 2'd0, '0, "R3 pins ignored");
      step(10'h155, 1'b1, 1'b1, 2'd1, {N{2'b01}}, "R3 code 01 write");
      step(10'h0F0, 1'b1, 1'b0, 2'd0, '0, "R3 code 01 serial only");
      step(10'h0F0, 1'b1, 1'b1, 2'd1, {N{2'b11}}, "R4 and write");
      step(10'h3F0, 1'b1, 1'b0, 2'd0, '0, "R4 and pattern");
      step(10'h00F, 1'b1, 1'b0, 2'd0, '0, "R5 pin low forces off");
      step(10'h3FF, 1'b1, 1'b1, 2'd3, 20'hFFFFF, "R8 reserved select");
      step(10'h3FF, 1'b1, 1'b0, 2'd0, '0, "R8 reserved select ignored");
      step(10'h3FF, 1'b1, 1'b1, 2'd0, 20'h00001, "R6 ser ch0 only");
      step(10'h3FF, 1'b1, 1'b1, 2'd2, 20'h00003, "R6 pair write");
      step(10'h3FF, 1'b1, 1'b0, 2'd0, '0, "R6 chain 0-1-2");
      step(10'h3FE, 1'b1, 1'b1, 2'd2, 20'h001FF, "R6 full chain write");
      step(10'h3FE, 1'b1, 1'b0, 2'd0, '0, "R6 full chain from ch0");
      step(10'h3FF, 1'b0, 1'b0, 2'd0, '0, "R7 enable low");
      step(10'h3FF, 1'b0, 1'b0, 2'd0, '0, "R7 enable held low");
      step(10'h3FF, 1'b1, 1'b0, 2'd0, '0, "R7 resume with stored settings");

      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] p;
         logic e, we;
         logic [1:0] s;
         logic [DW-1:0] d;
         p  = N'($urandom);
         e  = ($urandom % 10) != 0;
         we = ($urandom % 3) == 0;
         s  = 2'($urandom);
         d  = DW'($urandom);
         step(p, e, we, s, d, "random R2 R3 R4 R5 R6 R7 R8");
         if (k == 1500) do_reset();
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule